// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register Window

This block is the software-visible register file of an interrupt router. Software reaches it through two directly addressed registers: an 8-bit select register and a 32-bit data window. The select value chooses what the window shows. It can show an identification register, a fixed version register, an arbitration register that mirrors the identification field, or one 32-bit half of a 64-bit redirection entry. There is one redirection entry per interrupt input pin.

Each redirection entry describes how its pin is routed: vector, delivery mode, destination mode, delivery status, polarity, remote-IRR status, trigger mode, mask and destination. The remote-IRR status is owned by the delivery logic. That logic sets it through a per-pin input, and software can only clear it. The whole table is exported flat to the delivery logic, together with a one-cycle pulse per entry each time software writes that entry. A separate event reports every change of an entry's mask bit, carrying the entry index and the new mask value.

Entry bit layout: vector [7:0], delivery mode [10:8], destination mode [11], delivery status [12], polarity [13], remote IRR [14], trigger mode [15] (1 = level), mask [16], destination [63:56]. All other bits are stored as written.

Top module: `irq_window_regs`

## Requirements
- R1: After reset the select register reads 0, the identification field is 0, and every entry holds only its mask bit (lower half 0x0001_0000, upper half 0). No entry pulse and no mask event is active.
- R2: The select register lives at bus offset 0x00 and keeps only write-data bits 7:0, and only when byte enable 0 is set. It reads back zero-extended. Every offset other than 0x00 and 0x10 reads 0, and writes to such offsets change nothing.
- R3: Through the window at offset 0x10, select 0x01 reads {8'h00, NPINS-1, 8'h00, VERSION} in bits 31:24, 23:16, 15:8 and 7:0. Writes to it are ignored.
- R4: Select 0x00 holds a 4-bit identification in bits 27:24, written only when byte enable 3 is set. All other bits read 0. Select 0x02 reads the same value, and writes to select 0x02 are ignored.
- R5: For select values of 0x10 and above, the entry index is (select − 0x10) >> 1. An odd select accesses bits 63:32 and an even select accesses bits 31:0. Written values read back and appear on the exported table in the cycle after the write.
- R6: Select values 0x03 to 0x0F, and selects whose entry index is NPINS or more, read all ones. Writes to them change no entry and raise no pulse.
- R7: A window write updates only the bytes whose byte enable bit is set. Bits 7:0 of the data go to byte 0, bits 15:8 to byte 1, and so on.
- R8: Remote IRR (bit 14) is set only by the rirr_set input. Any lower-half write clears it, whatever the written data or byte enables, and this clear wins over a set in the same cycle. Upper-half writes leave it unchanged.
- R9: Every window write to an in-range entry raises that entry's bit of entry_wr for exactly the one cycle after the write. At most one bit is ever set.
- R10: When a write changes an entry's mask bit, mask_evt_valid is high in the same cycle as the entry pulse, with mask_evt_index set to the entry and mask_evt_value set to the new mask. A write that leaves the mask bit unchanged raises no event.
- R11: Read data is registered. It appears in the cycle after the read strobe and holds its value until the next read strobe, even when writes happen in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for writes |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| rirr_set | input | NPINS | Per-pin remote-IRR set from delivery logic |
| entry_table | output | NPINS*64 | All entries, entry i at bits [64*i+63:64*i] |
| entry_wr | output | NPINS | One-cycle pulse per entry written by software |
| mask_evt_valid | output | 1 | Mask bit of an entry changed |
| mask_evt_index | output | clog2(NPINS) | Entry whose mask changed |
| mask_evt_value | output | 1 | New mask value |

## Verification
The embedded assertions watch the following on every cycle:
- remote IRR never rises without a set request, and it is always clear after a lower-half write;
- every mask change comes with an event;
- the entry pulse vector is at most one-hot;
- discarded writes raise no pulse;
- the select register only moves on a select write.

The decoding itself can only be shown by the bench's read-back scenarios against its own model of the register map. That covers the version and identification contents, the index and half mapping, all-ones for unmapped selects, byte-lane merging and held read data.

// File: rtl/irqw_pkg.sv
// Package: shared constants, window target kinds and the byte-lane merge
// helper for the indirect redirection register window.
package irqw_pkg;

    localparam int ENTRY_W  = 64;
    localparam int HALF_W   = 32;
    localparam int BIT_RIRR = 14;
    localparam int BIT_MASK = 16;
    localparam int ID_LSB   = 24;
    localparam int ID_W     = 4;

    localparam logic [7:0] OFF_SELECT  = 8'h00;
    localparam logic [7:0] OFF_WINDOW  = 8'h10;
    localparam logic [7:0] SEL_IDENT   = 8'h00;
    localparam logic [7:0] SEL_VERSION = 8'h01;
    localparam logic [7:0] SEL_ARBIT   = 8'h02;
    localparam logic [7:0] SEL_TABLE   = 8'h10;

    typedef enum logic [2:0] {
        WK_IDENT,
        WK_VERSION,
        WK_ARBIT,
        WK_ENTRY,
        WK_VOID
    } win_kind_e;

    // Replace the bytes of old_v whose enable is set with bytes of new_v.
    function automatic logic [HALF_W-1:0] lane_merge(
        input logic [HALF_W-1:0] old_v,
        input logic [HALF_W-1:0] new_v,
        input logic [3:0]        be
    );
        logic [HALF_W-1:0] r;
        r = old_v;
        for (int b = 0; b < 4; b++) begin
            if (be[b]) r[8*b +: 8] = new_v[8*b +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/irqw_selreg.sv
// Module: irqw_selreg
// Holds the 8-bit select register and decodes it into a window target:
// identification, version, arbitration, one half of an entry, or void.
// Assumes NPINS <= 120, so that every index reachable by an 8-bit select fits
// in 7 bits.
module irqw_selreg
    import irqw_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int IDXW  = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_wr,
    input  logic [7:0]      sel_wdata,
    output logic [7:0]      sel_q,
    output win_kind_e       kind,
    output logic [IDXW-1:0] idx,
    output logic            upper
);
    localparam logic [6:0] PIN_LIMIT = 7'(NPINS);

    logic [7:0] off;
    logic [6:0] full_idx;

    // Select register: cleared by reset, loaded by a lane-0 select write.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (sel_wr) sel_q <= sel_wdata;
    end

    // Decode the select value into target kind, entry index and half.
    always_comb begin
        off      = sel_q - SEL_TABLE;
        full_idx = off[7:1];
        idx      = full_idx[IDXW-1:0];
        upper    = sel_q[0];
        if (sel_q == SEL_IDENT)          kind = WK_IDENT;
        else if (sel_q == SEL_VERSION)   kind = WK_VERSION;
        else if (sel_q == SEL_ARBIT)     kind = WK_ARBIT;
        else if (sel_q < SEL_TABLE)      kind = WK_VOID;
        else if (full_idx < PIN_LIMIT)   kind = WK_ENTRY;
        else                             kind = WK_VOID;
    end

    assert_sel_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sel_wr) |-> $stable(sel_q));

endmodule

// File: rtl/irqw_entry.sv
// Module: irqw_entry
// One 64-bit redirection entry. Software writes one half at a time with byte
// enables. Remote IRR is set by hardware and cleared by any lower-half write.
// The module also reports a write pulse and a mask-change flag.
// Assumes wr_lo and wr_hi are never both high.
module irqw_entry
    import irqw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [HALF_W-1:0]  wdata,
    input  logic [3:0]         be,
    input  logic               rirr_set,
    output logic [ENTRY_W-1:0] entry_q,
    output logic               wr_pulse,
    output logic               mask_chg
);
    localparam logic [ENTRY_W-1:0] RESET_VAL = ENTRY_W'(1) << BIT_MASK;

    logic [HALF_W-1:0] lo_new;
    logic [HALF_W-1:0] hi_new;

    // Merge write data into the halves; a lower-half write always drops remote IRR.
    always_comb begin
        lo_new           = lane_merge(entry_q[HALF_W-1:0], wdata, be);
        lo_new[BIT_RIRR] = 1'b0;
        hi_new           = lane_merge(entry_q[ENTRY_W-1:HALF_W], wdata, be);
    end

    // Entry storage, write pulse and mask-change flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q  <= RESET_VAL;
            wr_pulse <= 1'b0;
            mask_chg <= 1'b0;
        end else begin
            wr_pulse <= wr_lo | wr_hi;
            mask_chg <= wr_lo && (lo_new[BIT_MASK] != entry_q[BIT_MASK]);
            if (wr_hi) entry_q[ENTRY_W-1:HALF_W] <= hi_new;
            if (wr_lo)         entry_q[HALF_W-1:0] <= lo_new;
            else if (rirr_set) entry_q[BIT_RIRR]   <= 1'b1;
        end
    end

    assert_rirr_sw_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_lo) |-> !entry_q[BIT_RIRR]);

    assert_rirr_hw_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(entry_q[BIT_RIRR]) |-> $past(rirr_set));

    assert_mask_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_q[BIT_MASK] != $past(entry_q[BIT_MASK])) |-> mask_chg);

endmodule

// File: rtl/irq_window_regs.sv
// Module: irq_window_regs
// Register block of an interrupt router. A select register at offset 0x00 and
// a data window at offset 0x10 give indirect access to the identification,
// version and arbitration registers and to the redirection table. The module
// exports the table, per-entry write pulses and mask-change events.
// Assumes reads and writes are not issued in the same cycle.
module irq_window_regs
    import irqw_pkg::*;
#(
    parameter int         NPINS   = 24,
    parameter logic [7:0] VERSION = 8'h11,
    localparam int        IDXW    = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [7:0]               bus_addr,
    input  logic [31:0]              bus_wdata,
    input  logic [3:0]               bus_be,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    output logic [31:0]              bus_rdata,
    input  logic [NPINS-1:0]         rirr_set,
    output logic [NPINS*ENTRY_W-1:0] entry_table,
    output logic [NPINS-1:0]         entry_wr,
    output logic                     mask_evt_valid,
    output logic [IDXW-1:0]          mask_evt_index,
    output logic                     mask_evt_value
);
    logic [7:0]         sel_q;
    win_kind_e          kind;
    logic [IDXW-1:0]    idx;
    logic               upper;
    logic               sel_wr;
    logic               win_wr;
    logic [ID_W-1:0]    id_q;
    logic [IDXW-1:0]    evt_idx_q;
    logic [ENTRY_W-1:0] tbl [NPINS];
    logic [NPINS-1:0]   mask_chg;
    logic [31:0]        win_val;
    logic [31:0]        rd_val;

    assign sel_wr = bus_wr && (bus_addr == OFF_SELECT) && bus_be[0];
    assign win_wr = bus_wr && (bus_addr == OFF_WINDOW);

    irqw_selreg #(.NPINS(NPINS), .IDXW(IDXW)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_wr    (sel_wr),
        .sel_wdata (bus_wdata[7:0]),
        .sel_q     (sel_q),
        .kind      (kind),
        .idx       (idx),
        .upper     (upper)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_entry
        logic hit;
        assign hit = win_wr && (kind == WK_ENTRY) && (idx == IDXW'(g));
        irqw_entry u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (hit && !upper),
            .wr_hi    (hit && upper),
            .wdata    (bus_wdata),
            .be       (bus_be),
            .rirr_set (rirr_set[g]),
            .entry_q  (tbl[g]),
            .wr_pulse (entry_wr[g]),
            .mask_chg (mask_chg[g])
        );
        assign entry_table[g*ENTRY_W +: ENTRY_W] = tbl[g];
    end

    // Identification register: window write at select 0 with lane 3 enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            id_q <= '0;
        else if (win_wr && kind == WK_IDENT && bus_be[3])
            id_q <= bus_wdata[ID_LSB +: ID_W];
    end

    // Remember the index of the last entry write for the mask event.
    always_ff @(posedge clk) begin
        if (!rst_n)                          evt_idx_q <= '0;
        else if (win_wr && kind == WK_ENTRY) evt_idx_q <= idx;
    end

    assign mask_evt_valid = |mask_chg;
    assign mask_evt_index = evt_idx_q;
    assign mask_evt_value = tbl[evt_idx_q][BIT_MASK];

    // Window read value for the current select target.
    always_comb begin
        unique case (kind)
            WK_IDENT, WK_ARBIT: win_val = {4'h0, id_q, 24'h0};
            WK_VERSION:         win_val = {8'h00, 8'(NPINS - 1), 8'h00, VERSION};
            WK_ENTRY:           win_val = upper ? tbl[idx][ENTRY_W-1:HALF_W]
                                                : tbl[idx][HALF_W-1:0];
            default:            win_val = '1;
        endcase
    end

    // Direct offset decode for reads.
    always_comb begin
        if (bus_addr == OFF_SELECT)      rd_val = {24'h0, sel_q};
        else if (bus_addr == OFF_WINDOW) rd_val = win_val;
        else                             rd_val = '0;
    end

    // Registered read data, held between read strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end

    assert_one_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(entry_wr));

    assert_void_discard_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && kind == WK_VOID) |=> (entry_wr == '0));

    assert_evt_with_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mask_evt_valid |-> (entry_wr != '0));

endmodule

// File: tb/test_irq_window_regs.sv
// Bench: directed corner cases plus seeded random traffic, checked against a
// bench-side model of the register map.
`timescale 1ns/1ps
module test_irq_window_regs;
    localparam int NP  = 24;
    localparam int IW  = 5;
    localparam logic [7:0] VER = 8'h11;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [3:0]      bus_be = '0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [31:0]     bus_rdata;
    logic [NP-1:0]   rirr_set = '0;
    logic [NP*64-1:0] entry_table;
    logic [NP-1:0]   entry_wr;
    logic            mask_evt_valid;
    logic [IW-1:0]   mask_evt_index;
    logic            mask_evt_value;

    int checks = 0;
    int errors = 0;

    logic [63:0] m_ent [NP];
    logic [7:0]  m_sel;
    logic [3:0]  m_id;

    always #2.5 clk = ~clk;

    irq_window_regs #(.NPINS(NP), .VERSION(VER)) i_irq_window_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_be(bus_be), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .rirr_set(rirr_set), .entry_table(entry_table), .entry_wr(entry_wr),
        .mask_evt_valid(mask_evt_valid), .mask_evt_index(mask_evt_index),
        .mask_evt_value(mask_evt_value)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                          input logic [3:0] be);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    function automatic bit sel_is_entry(input logic [7:0] s);
        return (s >= 8'h10) && (((int'(s) - 16) >> 1) < NP);
    endfunction

    function automatic logic [31:0] exp_win(input logic [7:0] s);
        int i;
        if (s == 8'h00 || s == 8'h02) return {4'h0, m_id, 24'h0};
        if (s == 8'h01) return {8'h00, 8'(NP - 1), 8'h00, VER};
        if (!sel_is_entry(s)) return 32'hFFFF_FFFF;
        i = (int'(s) - 16) >> 1;
        return s[0] ? m_ent[i][63:32] : m_ent[i][31:0];
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_sel(input logic [7:0] s);
        bus_write(8'h00, {24'h0, s}, 4'h1);
        m_sel = s;
    endtask

    // Window write with model update and pulse/event/export checks (R5, R9, R10).
    task automatic win_write(input logic [7:0] s, input logic [31:0] d, input logic [3:0] be);
        logic [NP-1:0] exp_pulse = '0;
        logic          exp_evt = 1'b0;
        int            i = 0;
        logic [31:0]   nv;
        set_sel(s);
        if (s == 8'h00 && be[3]) m_id = d[27:24];
        if (sel_is_entry(s)) begin
            i = (int'(s) - 16) >> 1;
            exp_pulse[i] = 1'b1;
            if (s[0]) m_ent[i][63:32] = merge(m_ent[i][63:32], d, be);
            else begin
                nv = merge(m_ent[i][31:0], d, be);
                nv[14] = 1'b0;
                exp_evt = (nv[16] != m_ent[i][16]);
                m_ent[i][31:0] = nv;
            end
        end
        bus_write(8'h10, d, be);
        chk("R9 entry_wr pulse", 64'(entry_wr), 64'(exp_pulse));
        chk("R10 mask_evt_valid", 64'(mask_evt_valid), 64'(exp_evt));
        if (exp_evt) begin
            chk("R10 mask_evt_index", 64'(mask_evt_index), 64'(i));
            chk("R10 mask_evt_value", 64'(mask_evt_value), 64'(m_ent[i][16]));
        end
        if (sel_is_entry(s)) chk("R5 exported entry", entry_table[i*64 +: 64], m_ent[i]);
    endtask

    task automatic win_read_chk(input string req, input logic [7:0] s);
        logic [31:0] d;
        set_sel(s);
        bus_read(8'h10, d);
        chk(req, 64'(d), 64'(exp_win(s)));
    endtask

    task automatic pulse_rirr(input int i);
        @(negedge clk);
        rirr_set = '0; rirr_set[i] = 1'b1;
        @(negedge clk);
        rirr_set = '0;
        m_ent[i][14] = 1'b1;
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] held;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NP; i++) m_ent[i] = 64'h0000_0000_0001_0000;
        m_sel = '0; m_id = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 entry_wr idle", 64'(entry_wr), 64'h0);
        chk("R1 mask_evt idle", 64'(mask_evt_valid), 64'h0);
        for (int i = 0; i < NP; i++)
            chk("R1 exported entry reset", entry_table[i*64 +: 64], 64'h0000_0000_0001_0000);
        bus_read(8'h00, d);
        chk("R1 select reset", 64'(d), 64'h0);
        bus_read(8'h10, d);
        chk("R1 id reset", 64'(d), 64'h0);
        win_read_chk("R1 entry5 low reset", 8'h1A);
        win_read_chk("R1 entry5 high reset", 8'h1B);

        // R2 select register and other offsets
        bus_write(8'h00, 32'hABCD_EF5A, 4'hF); m_sel = 8'h5A;
        bus_read(8'h00, d);
        chk("R2 select keeps low byte", 64'(d), 64'h5A);
        bus_write(8'h00, 32'h0000_0033, 4'hE);
        bus_read(8'h00, d);
        chk("R2 select ignores without lane0", 64'(d), 64'h5A);
        bus_read(8'h08, d);
        chk("R2 other offset reads zero", 64'(d), 64'h0);
        bus_write(8'h08, 32'h0000_0077, 4'hF);
        bus_read(8'h00, d);
        chk("R2 other offset write ignored", 64'(d), 64'h5A);

        // R3 version
        win_read_chk("R3 version value", 8'h01);
        win_write(8'h01, 32'hFFFF_FFFF, 4'hF);
        win_read_chk("R3 version write ignored", 8'h01);

        // R4 identification and arbitration
        win_write(8'h00, 32'h5F12_3456, 4'hF);
        win_read_chk("R4 id field", 8'h00);
        win_read_chk("R4 arbitration mirrors id", 8'h02);
        win_write(8'h02, 32'h0300_0000, 4'hF);
        win_read_chk("R4 arbitration write ignored", 8'h00);
        win_write(8'h00, 32'h0200_0000, 4'h7);
        win_read_chk("R4 id needs lane3", 8'h00);

        // R5 entry mapping and R10 mask change
        win_write(8'h16, 32'h0000_A0B1, 4'hF);
        win_write(8'h17, 32'h7700_0000, 4'hF);
        win_read_chk("R5 entry3 low", 8'h16);
        win_read_chk("R5 entry3 high", 8'h17);
        win_read_chk("R5 entry4 untouched", 8'h18);
        win_write(8'h16, 32'h0000_A0B2, 4'hF);
        win_write(8'h3E, 32'h0001_0055, 4'hF);
        win_read_chk("R5 last entry low", 8'h3E);

        // R6 unmapped selects
        win_read_chk("R6 index beyond pins reads ones", 8'h40);
        win_read_chk("R6 low select gap reads ones", 8'h05);
        win_write(8'h40, 32'h1234_5678, 4'hF);
        win_write(8'h0B, 32'h1234_5678, 4'hF);
        win_read_chk("R6 entry23 after discarded write", 8'h3E);

        // R7 byte lanes
        win_write(8'h1E, 32'hDEAD_BEEF, 4'b0001);
        win_read_chk("R7 lane0 only", 8'h1E);
        win_write(8'h1F, 32'hCAFE_F00D, 4'b1010);
        win_read_chk("R7 lanes 1 and 3", 8'h1F);

        // R8 remote IRR
        pulse_rirr(3);
        win_read_chk("R8 remote irr set by hardware", 8'h16);
        win_write(8'h17, 32'h1100_0000, 4'hF);
        win_read_chk("R8 upper write keeps remote irr", 8'h16);
        win_write(8'h16, 32'h0000_40B2, 4'h0);
        win_read_chk("R8 lower write clears remote irr", 8'h16);
        win_write(8'h16, 32'h0000_40B2, 4'hF);
        win_read_chk("R8 software cannot set remote irr", 8'h16);

        // R11 read hold
        set_sel(8'h01);
        bus_read(8'h10, held);
        win_write(8'h10, 32'h0000_0099, 4'hF);
        chk("R11 read data held", 64'(bus_rdata), 64'(held));
        chk("R11 held value is version", 64'(held), 64'h0017_0011);

        // Random traffic
        for (int n = 0; n < 400; n++) begin
            int r = $urandom % 20;
            int k = $urandom % 10;
            logic [7:0] s;
            if (k < 1)      s = 8'($urandom % 3);
            else if (k < 2) s = ($urandom % 2 == 0) ? 8'(3 + $urandom % 13)
                                                    : 8'(8'h40 + $urandom % 192);
            else            s = 8'(8'h10 + $urandom % 48);
            if (r < 9)       win_write(s, $urandom, 4'($urandom));
            else if (r < 19) win_read_chk(sel_is_entry(s) ? "R5 random read" :
                                          (s < 3 ? "R4 random read" : "R6 random read"), s);
            else             pulse_rirr($urandom % NP);
        end
        for (int i = 0; i < NP; i++)
            chk("R5 final table", entry_table[i*64 +: 64], m_ent[i]);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule